// File: doc/BRIEF.md
# Prescaled Poll Timeout Timer

This block bounds how long a descriptor-driven peripheral engine may sit waiting on a polled condition. When a wait begins, the engine pulses `start_i` together with two selector fields. One field picks a clock divider and the other picks how many divided ticks may pass. The block samples both fields on that edge and then counts silently. If the wait is not cancelled or restarted before the tick budget runs out, the block raises `timeout_o` for one cycle and sets a sticky status flag. That flag stays set until the engine clears it.

Timing has two stages. A prescaler turns the system clock into ticks. Its period is 2^SHIFT_LO, 2^SHIFT_MID or 2^SHIFT_HI cycles, with defaults of 2^8, 2^16 and 2^24. Selector code 0 disables the timeout entirely. A tick counter then compares against a limit of 4 << tick code, which gives 4 to 512 ticks. The shift amounts are parameters, so a short test can use small dividers.

Top module: `poll_timeout_timer`

## Requirements
- R1: After a synchronous active-low reset, `timeout_o` and `status_o` are both 0.
- R2: The tick limit is 4 << `tick_sel_i`, so codes 0..7 give 4, 8, 16, 32, 64, 128, 256 and 512 ticks. With an active prescaler of P cycles per tick, `timeout_o` is high in the cycle that follows the clock edge lying exactly limit*P edges after the edge that sampled `start_i`.
- R3: `div_sel_i` codes 1, 2 and 3 give P = 2^SHIFT_LO, 2^SHIFT_MID and 2^SHIFT_HI clock cycles per tick.
- R4: A wait started with `div_sel_i` = 0 never produces `timeout_o`, and `status_o` keeps its value, whether that value is 0 or 1.
- R5: `timeout_o` is high for exactly one cycle, and there is at most one pulse per start.
- R6: `status_o` becomes 1 on the same edge that raises `timeout_o`. If `stat_clr_i` is sampled on that same edge, the set wins.
- R7: `stat_clr_i` sampled on an edge with no expiry makes `status_o` 0 from that edge onward.
- R8: `cancel_i` (without `start_i`) ends the running wait, and no timeout follows from it.
- R9: `start_i` during a running wait restarts both counters from zero. The pulse then comes limit*P edges after the new start, and the earlier wait produces none.
- R10: The selector fields are taken only on the edge that samples `start_i`. Changing them later has no effect on the running wait.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begin (or restart) a timed wait; samples the selectors |
| cancel_i | input | 1 | Abandon the running wait without a timeout |
| tick_sel_i | input | 3 | Tick limit code, limit = 4 << code |
| div_sel_i | input | 2 | Prescaler code: 0 off, 1/2/3 select the three dividers |
| stat_clr_i | input | 1 | Clear the sticky timeout status |
| timeout_o | output | 1 | One-cycle pulse at expiry |
| status_o | output | 1 | Sticky timeout status flag |

## Verification
The assertions take for granted that `start_i`, `cancel_i` and `stat_clr_i` are synchronous single-cycle strobes, and that the captured prescaler code is meaningful only from the start edge onward. The stimulus respects this. Every strobe is driven on a falling edge and dropped just after the rising edge that samples it, and selector changes are made only between starts or in the middle of a wait. The dividers are overridden to 4, 8 and 16 cycles. With those values the bench can run all eight tick limits and all three active prescaler codes to expiry, including the largest case of 512 ticks at 16 cycles each.

// File: rtl/pto_pkg.sv
// Package: shared widths, the prescaler code type and the tick-limit function
// for the poll timeout timer. Assumes the tick limit base is 4 ticks.
package pto_pkg;
    localparam int TICK_SEL_W = 3;
    localparam int DIV_SEL_W  = 2;
    localparam int LIMIT_BASE = 4;
    localparam int MAX_LIMIT  = LIMIT_BASE << ((1 << TICK_SEL_W) - 1);
    localparam int TICK_CNT_W = $clog2(MAX_LIMIT);

    typedef enum logic [DIV_SEL_W-1:0] {
        DIV_OFF  = 2'd0,
        DIV_LOW  = 2'd1,
        DIV_MID  = 2'd2,
        DIV_HIGH = 2'd3
    } div_sel_e;

    // Last tick index (limit - 1) for a given tick selector code.
    function automatic logic [TICK_CNT_W-1:0] last_tick(input logic [TICK_SEL_W-1:0] code);
        return TICK_CNT_W'((LIMIT_BASE << code) - 1);
    endfunction
endpackage

// File: rtl/pto_prescaler.sv
// Module: pto_prescaler
// Divides the clock into one-cycle tick strobes. The period is 2^SHIFT_x
// cycles, picked by the captured prescaler code. Assumes
// SHIFT_LO <= SHIFT_MID <= SHIFT_HI and SHIFT_HI >= 1.
module pto_prescaler
    import pto_pkg::*;
#(
    parameter int SHIFT_LO  = 8,
    parameter int SHIFT_MID = 16,
    parameter int SHIFT_HI  = 24
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     clear_i,
    input  logic     run_i,
    input  div_sel_e div_i,
    output logic     tick_o
);
    localparam int CNT_W = SHIFT_HI;
    localparam logic [CNT_W-1:0] END_LO  = CNT_W'((64'd1 << SHIFT_LO) - 64'd1);
    localparam logic [CNT_W-1:0] END_MID = CNT_W'((64'd1 << SHIFT_MID) - 64'd1);
    localparam logic [CNT_W-1:0] END_HI  = CNT_W'((64'd1 << SHIFT_HI) - 64'd1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] end_val;

    // Pick the terminal count for the captured divider code.
    always_comb begin
        case (div_i)
            DIV_LOW:  end_val = END_LO;
            DIV_MID:  end_val = END_MID;
            DIV_HIGH: end_val = END_HI;
            default:  end_val = '0;
        endcase
    end

    assign tick_o = run_i && (div_i != DIV_OFF) && (cnt_q == end_val);

    // Free-running divider counter, zeroed on start and wrapped at each tick.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            cnt_q <= '0;
        end else if (run_i) begin
            cnt_q <= tick_o ? '0 : cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/pto_tick_counter.sv
// Module: pto_tick_counter
// Counts prescaler ticks and flags the tick that reaches the captured limit.
// Assumes tick_i is a one-cycle strobe and that clear_i marks each start.
module pto_tick_counter
    import pto_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clear_i,
    input  logic                  tick_i,
    input  logic [TICK_SEL_W-1:0] tick_sel_i,
    output logic                  last_o
);
    logic [TICK_CNT_W-1:0] cnt_q;

    assign last_o = tick_i && (cnt_q == last_tick(tick_sel_i));

    // Tick accumulator, zeroed on start.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            cnt_q <= '0;
        end else if (tick_i) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/pto_status_flag.sv
// Module: pto_status_flag
// Sticky status bit: a set wins over a clear on the same edge.
module pto_status_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    // Hold the flag until an explicit clear arrives without a set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_o <= 1'b0;
        end else if (set_i) begin
            flag_o <= 1'b1;
        end else if (clr_i) begin
            flag_o <= 1'b0;
        end
    end
endmodule

// File: rtl/poll_timeout_timer.sv
// Module: poll_timeout_timer
// Bounds a polled wait. It samples the selectors on start, counts prescaled
// ticks, and at the limit gives a one-cycle timeout pulse and sets a sticky
// status. Start has priority over cancel, and cancel over expiry.
module poll_timeout_timer
    import pto_pkg::*;
#(
    parameter int SHIFT_LO  = 8,
    parameter int SHIFT_MID = 16,
    parameter int SHIFT_HI  = 24
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start_i,
    input  logic                  cancel_i,
    input  logic [TICK_SEL_W-1:0] tick_sel_i,
    input  logic [DIV_SEL_W-1:0]  div_sel_i,
    input  logic                  stat_clr_i,
    output logic                  timeout_o,
    output logic                  status_o
);
    logic                  run_q;
    logic [TICK_SEL_W-1:0] tick_q;
    div_sel_e              div_q;
    logic                  tick;
    logic                  last;
    logic                  expire;

    assign expire = run_q && last && !start_i && !cancel_i;

    // Wait control: capture selectors on start, stop on cancel or expiry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q  <= 1'b0;
            tick_q <= '0;
            div_q  <= DIV_OFF;
        end else if (start_i) begin
            run_q  <= (div_sel_i != DIV_OFF);
            tick_q <= tick_sel_i;
            div_q  <= div_sel_e'(div_sel_i);
        end else if (cancel_i || expire) begin
            run_q  <= 1'b0;
        end
    end

    // One-cycle timeout pulse register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            timeout_o <= 1'b0;
        end else begin
            timeout_o <= expire;
        end
    end

    pto_prescaler #(
        .SHIFT_LO (SHIFT_LO),
        .SHIFT_MID(SHIFT_MID),
        .SHIFT_HI (SHIFT_HI)
    ) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear_i(start_i),
        .run_i  (run_q),
        .div_i  (div_q),
        .tick_o (tick)
    );

    pto_tick_counter u_ticks (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (start_i),
        .tick_i    (tick),
        .tick_sel_i(tick_q),
        .last_o    (last)
    );

    pto_status_flag u_flag (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (expire),
        .clr_i (stat_clr_i),
        .flag_o(status_o)
    );
endmodule

// File: rtl/pto_checker.sv
// Module: pto_checker
// Temporal checks on the timeout timer, bound into every instance.
// Assumes the strobes are synchronous to clk.
module pto_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       start_i,
    input logic       cancel_i,
    input logic       stat_clr_i,
    input logic       timeout_o,
    input logic       status_o,
    input logic [1:0] div_cap
);
    // R5: the pulse never lasts two cycles.
    p_single_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_o |=> !timeout_o);

    // R6: status is set whenever the pulse is seen.
    p_status_with_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_o |-> status_o);

    // R6: status rises only together with a pulse.
    p_status_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status_o) |-> timeout_o);

    // R7: a clear leaves status low unless an expiry coincided.
    p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        stat_clr_i |=> (!status_o || timeout_o));

    // R8: cancel suppresses any pulse on the following cycle.
    p_cancel_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cancel_i && !start_i) |=> !timeout_o);

    // R9: a start suppresses any pulse on the following cycle.
    p_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> !timeout_o);

    // R4: a pulse only comes from a wait with an active prescaler.
    p_off_never_r4: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_o |-> ($past(div_cap) != 2'd0));
endmodule

bind poll_timeout_timer pto_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .cancel_i  (cancel_i),
    .stat_clr_i(stat_clr_i),
    .timeout_o (timeout_o),
    .status_o  (status_o),
    .div_cap   (div_q)
);

// File: tb/tb_poll_timeout_timer.sv
// Scoreboard bench: the driver queues the cycle at which each pulse is due,
// and a monitor pops an entry whenever timeout_o is seen.
module tb_poll_timeout_timer;
    localparam int CLK_PERIOD = 10;
    localparam int S_LO  = 2;
    localparam int S_MID = 3;
    localparam int S_HI  = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic       cancel_i = 1'b0;
    logic [2:0] tick_sel_i = '0;
    logic [1:0] div_sel_i = '0;
    logic       stat_clr_i = 1'b0;
    logic       timeout_o;
    logic       status_o;

    int unsigned cyc = 0;
    int checks = 0;
    int errors = 0;
    int unsigned exp_q[$];
    logic prev_to = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    poll_timeout_timer #(.SHIFT_LO(S_LO), .SHIFT_MID(S_MID), .SHIFT_HI(S_HI)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .cancel_i(cancel_i),
        .tick_sel_i(tick_sel_i), .div_sel_i(div_sel_i), .stat_clr_i(stat_clr_i),
        .timeout_o(timeout_o), .status_o(status_o)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int period(input logic [1:0] d);
        case (d)
            2'd1: return 1 << S_LO;
            2'd2: return 1 << S_MID;
            2'd3: return 1 << S_HI;
            default: return 0;
        endcase
    endfunction

    // Monitor: compare each pulse with the scoreboard (R2, R3, R5, R6).
    always @(negedge clk) begin
        if (rst_n) begin
            if (timeout_o) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R4/R8/R9 unexpected pulse", int'(cyc), -1);
                end else begin
                    int unsigned e;
                    e = exp_q.pop_front();
                    chk(cyc == e, "R2/R3 pulse cycle", int'(cyc), int'(e));
                    chk(status_o == 1'b1, "R6 status with pulse", status_o, 1);
                end
                chk(!prev_to, "R5 pulse width", prev_to, 0);
            end
            prev_to <= timeout_o;
        end
    end

    // Driver: one start strobe; optionally queue the expected pulse cycle.
    task automatic do_start(input logic [2:0] t, input logic [1:0] d, input bit expect_pulse);
        @(negedge clk);
        tick_sel_i = t;
        div_sel_i  = d;
        start_i    = 1'b1;
        @(posedge clk);
        #1;
        start_i = 1'b0;
        if (expect_pulse)
            exp_q.push_back(cyc + ((4 << t) * period(d)));
    endtask

    task automatic strobe_clear();
        @(negedge clk);
        stat_clr_i = 1'b1;
        @(posedge clk);
        #1;
        stat_clr_i = 1'b0;
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
        @(negedge clk);
        chk(timeout_o == 1'b0, "R5 pulse ended", timeout_o, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(timeout_o == 1'b0, "R1 reset timeout", timeout_o, 0);
        chk(status_o == 1'b0, "R1 reset status", status_o, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2, R3: every tick limit with the lowest divider.
        for (int t = 0; t < 8; t++) begin
            do_start(3'(t), 2'd1, 1'b1);
            drain();
            chk(status_o == 1'b1, "R6 status sticky", status_o, 1);
            strobe_clear();
            @(negedge clk);
            chk(status_o == 1'b0, "R7 clear", status_o, 0);
        end

        // R3: middle and high dividers, including the longest budget.
        do_start(3'd0, 2'd2, 1'b1); drain();
        do_start(3'd3, 2'd2, 1'b1); drain();
        do_start(3'd0, 2'd3, 1'b1); drain();
        do_start(3'd7, 2'd3, 1'b1); drain();
        strobe_clear();

        // R4: prescaler off with status at 0, then at 1.
        do_start(3'd0, 2'd0, 1'b0);
        repeat (600) @(negedge clk);
        chk(status_o == 1'b0, "R4 off keeps status 0", status_o, 0);
        do_start(3'd0, 2'd1, 1'b1); drain();
        do_start(3'd0, 2'd0, 1'b0);
        repeat (600) @(negedge clk);
        chk(status_o == 1'b1, "R4 off keeps status 1", status_o, 1);
        strobe_clear();

        // R8: cancel halfway, then wait past the original deadline.
        do_start(3'd2, 2'd1, 1'b0);
        repeat (30) @(negedge clk);
        cancel_i = 1'b1;
        @(posedge clk); #1;
        cancel_i = 1'b0;
        repeat (200) @(negedge clk);
        chk(status_o == 1'b0, "R8 cancel no status", status_o, 0);

        // R9: restart during a wait; only the second start times out.
        do_start(3'd1, 2'd1, 1'b0);
        repeat (20) @(negedge clk);
        do_start(3'd1, 2'd1, 1'b1);
        drain();
        strobe_clear();

        // R10: change selectors during the wait.
        do_start(3'd0, 2'd1, 1'b1);
        @(negedge clk);
        tick_sel_i = 3'd7;
        div_sel_i  = 2'd3;
        drain();
        strobe_clear();

        // R6: a clear on the expiry edge loses to the set.
        do_start(3'd0, 2'd1, 1'b1);
        begin
            int unsigned e;
            e = exp_q[0];
            while (cyc != e - 1) @(negedge clk);
            stat_clr_i = 1'b1;
            @(posedge clk); #1;
            stat_clr_i = 1'b0;
        end
        @(negedge clk);
        chk(status_o == 1'b1, "R6 set beats clear", status_o, 1);
        strobe_clear();
        @(negedge clk);
        chk(status_o == 1'b0, "R7 later clear", status_o, 0);

        repeat (50) @(negedge clk);
        chk(exp_q.size() == 0, "R2 all pulses seen", exp_q.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule